// File: doc/BRIEF.md
# Memory-Mapped Disk Task-File Window Decoder

This block sits between a host memory bus and the register port of a disk-controller core. It takes a 4 KiB window of the host's address space and gives each disk register a 16-byte slot in it. Byte accesses reach the seven task-file registers and the device-control / alternate-status register. Halfword and word accesses reach only the data port. The data port keeps a byte order opposite to the host's, so wide data is byte-reversed in both directions. The window base is decoded upstream, so the block receives only the 12-bit offset into the window.

The host side uses a valid/ready request channel. Read data comes back on a separate valid strobe exactly one cycle after the request is accepted. The downstream port carries a register number, a write enable, the access size and the already-swapped write data, all in the cycle the request is accepted. It returns read data on the following cycle. If a request targets no register, nothing is sent downstream. Such a read returns all ones at the requested width, and such a write is dropped.

Top module: `ide_win_decode`

## Requirements
- R1: The slot index is the window offset shifted right by 4 (offset bits [11:4]). Offset bits [3:0] have no effect on decode or on data.
- R2: A byte access (size code 0) at slot 1 to 7 strobes downstream register t_reg equal to the slot number, for both reads and writes.
- R3: A byte access at slot 8 or slot 22 strobes t_reg = 8. This is the device-control register on a write and the alternate-status register on a read.
- R4: A byte access at any other slot, including slot 0, produces no downstream strobe. A read there returns 0x000000FF.
- R5: A halfword (size code 1) or word (size code 2) access at slot 0 strobes t_reg = 0 with t_size equal to the host size. At any other slot there is no strobe, and a read returns 0x0000FFFF for a halfword or 0xFFFFFFFF for a word. Size code 3 never strobes, and a read with it returns 0xFFFFFFFF.
- R6: For a halfword access, t_wdata = {16'h0, wdata[7:0], wdata[15:8]}. Read data returned to the host is {16'h0, t_rdata[7:0], t_rdata[15:8]}.
- R7: For a word access, all four bytes are reversed in both directions: host byte 0 maps to downstream byte 3, and so on.
- R8: For a byte access, t_wdata = {24'h0, wdata[7:0]}. Read data returned to the host is {24'h0, t_rdata[7:0]}.
- R9: The downstream strobe, register, write enable, size and data appear in the same cycle as the host handshake. h_rvalid is high in the next cycle for reads only, and never after writes.
- R10: While rst is high, h_ready and t_stb are low. In the cycle after a reset cycle, h_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| h_off | input | WIN_BITS (12) | Byte offset inside the window |
| h_wdata | input | 32 | Host write data, least significant bits used for narrow sizes |
| h_rvalid | output | 1 | Read data valid, one cycle after a read is accepted |
| h_rdata | output | 32 | Read data |
| t_stb | output | 1 | Downstream register access strobe |
| t_we | output | 1 | Downstream write enable |
| t_reg | output | 4 | Downstream register number (0 data, 1-7 task file, 8 control/alt status) |
| t_size | output | 2 | Access size passed downstream |
| t_wdata | output | 32 | Byte-steered, swapped write data |
| t_rdata | input | 32 | Downstream read data, valid the cycle after a read strobe |

## Verification
Every cycle, the assertions check the structural rules. No strobe is issued without an accepted request. Wide accesses reach only register 0, and byte accesses never do. The read-return strobe follows reads but never writes. Unmapped byte reads return 0xFF, and reset keeps everything quiet. The exact byte lanes are shown only by the bench's scenarios. These cover the halfword and word swaps in both directions, the write-then-read round trips through a modelled register file, the aliasing of slot 22 onto register 8, and the independence from offset bits [3:0].

// File: rtl/ide_win_decode.sv
module ide_win_decode #(
  parameter int WIN_BITS  = 12,
  parameter int SLOT_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_valid,
  output logic                h_ready,
  input  logic                h_write,
  input  logic [1:0]          h_size,
  input  logic [WIN_BITS-1:0] h_off,
  input  logic [31:0]         h_wdata,
  output logic                h_rvalid,
  output logic [31:0]         h_rdata,
  output logic                t_stb,
  output logic                t_we,
  output logic [3:0]          t_reg,
  output logic [1:0]          t_size,
  output logic [31:0]         t_wdata,
  input  logic [31:0]         t_rdata
);

  localparam logic [WIN_BITS-1:0] SLOT_CTL_A = WIN_BITS'(8);
  localparam logic [WIN_BITS-1:0] SLOT_CTL_B = WIN_BITS'(22);

  logic [WIN_BITS-1:0] slot;
  logic                is_tf, is_ctl, is_data, hit, take;
  logic                rd_pend, rd_hit;
  logic [1:0]          rd_size;

  assign slot    = h_off >> SLOT_BITS;
  assign is_tf   = (slot >= WIN_BITS'(1)) && (slot <= WIN_BITS'(7));
  assign is_ctl  = (slot == SLOT_CTL_A) || (slot == SLOT_CTL_B);
  assign is_data = (slot == '0);

  always_comb begin
    case (h_size)
      2'd0:    hit = is_tf | is_ctl;
      2'd1,
      2'd2:    hit = is_data;
      default: hit = 1'b0;
    endcase
  end

  assign h_ready = ~rst;
  assign take    = h_valid & h_ready;

  assign t_stb  = take & hit;
  assign t_we   = h_write;
  assign t_size = h_size;
  assign t_reg  = is_ctl ? 4'd8 : slot[3:0];

  always_comb begin
    case (h_size)
      2'd1:    t_wdata = {16'h0, h_wdata[7:0], h_wdata[15:8]};
      2'd2:    t_wdata = {h_wdata[7:0], h_wdata[15:8], h_wdata[23:16], h_wdata[31:24]};
      default: t_wdata = {24'h0, h_wdata[7:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_hit  <= 1'b0;
      rd_size <= 2'd0;
    end else begin
      rd_pend <= take & ~h_write;
      rd_hit  <= hit;
      rd_size <= h_size;
    end
  end

  assign h_rvalid = rd_pend;

  always_comb begin
    case (rd_size)
      2'd0:    h_rdata = rd_hit ? {24'h0, t_rdata[7:0]} : 32'h0000_00FF;
      2'd1:    h_rdata = rd_hit ? {16'h0, t_rdata[7:0], t_rdata[15:8]} : 32'h0000_FFFF;
      2'd2:    h_rdata = rd_hit ? {t_rdata[7:0], t_rdata[15:8], t_rdata[23:16], t_rdata[31:24]}
                                : 32'hFFFF_FFFF;
      default: h_rdata = 32'hFFFF_FFFF;
    endcase
  end

endmodule

// File: rtl/ide_win_decode_chk.sv
module ide_win_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        h_valid,
  input logic        h_ready,
  input logic        h_write,
  input logic [1:0]  h_size,
  input logic        h_rvalid,
  input logic [31:0] h_rdata,
  input logic        t_stb,
  input logic [3:0]  t_reg,
  input logic [1:0]  t_size
);

  AST_STB_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    t_stb |-> (h_valid && h_ready)) else $error("AST_STB_NEEDS_REQ");    // R9

  AST_WIDE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    (t_stb && t_size != 2'd0) |-> (t_reg == 4'd0)) else $error("AST_WIDE_DATA_ONLY"); // R5

  AST_NO_WIDE_RESERVED: assert property (@(posedge clk) disable iff (rst)
    t_stb |-> (t_size != 2'd3)) else $error("AST_NO_WIDE_RESERVED");  // R5

  AST_BYTE_NOT_DATA: assert property (@(posedge clk) disable iff (rst)
    (t_stb && t_size == 2'd0) |-> (t_reg != 4'd0 && t_reg <= 4'd8)) else $error("AST_BYTE_NOT_DATA"); // R2

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && !h_write) |=> h_rvalid) else $error("AST_READ_RETURNS"); // R9

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && h_write) |=> !h_rvalid) else $error("AST_WRITE_SILENT"); // R9

  AST_UNMAPPED_BYTE_FF: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && !h_write && !t_stb && h_size == 2'd0) |=> (h_rdata == 32'h0000_00FF))
    else $error("AST_UNMAPPED_BYTE_FF");                                // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!h_ready && !t_stb)) else $error("AST_RESET_QUIET");        // R10

  AST_RESET_NO_RVALID: assert property (@(posedge clk)
    rst |=> !h_rvalid) else $error("AST_RESET_NO_RVALID");               // R10

endmodule

bind ide_win_decode ide_win_decode_chk u_chk (
  .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
  .h_size(h_size), .h_rvalid(h_rvalid), .h_rdata(h_rdata), .t_stb(t_stb),
  .t_reg(t_reg), .t_size(t_size)
);

// File: tb/ide_win_decode_test.sv
module ide_win_decode_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [1:0]  h_size = 2'd0;
  logic [11:0] h_off = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_rvalid, t_stb, t_we;
  logic [31:0] h_rdata, t_wdata;
  logic [31:0] t_rdata = '0;
  logic [3:0]  t_reg;
  logic [1:0]  t_size;

  int total = 0, bad = 0;
  logic [31:0] dmem [0:8];
  logic [31:0] smem [0:8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_win_decode uut (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_size(h_size), .h_off(h_off), .h_wdata(h_wdata), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .t_stb(t_stb), .t_we(t_we), .t_reg(t_reg), .t_size(t_size),
    .t_wdata(t_wdata), .t_rdata(t_rdata)
  );

  always @(posedge clk)
    if (t_stb && t_reg <= 4'd8) begin
      if (t_we) dmem[t_reg] <= t_wdata;
      else      t_rdata     <= dmem[t_reg];
    end

  function automatic bit exp_hit(input logic [1:0] sz, input logic [11:0] off);
    int s = int'(off >> 4);
    if (sz == 2'd0) return (s >= 1 && s <= 8) || s == 22;
    if (sz == 2'd1 || sz == 2'd2) return s == 0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_reg(input logic [11:0] off);
    int s = int'(off >> 4);
    return (s == 22) ? 4'd8 : 4'(s);
  endfunction

  function automatic logic [31:0] swap_out(input logic [1:0] sz, input logic [31:0] v);
    case (sz)
      2'd1:    return {16'h0, v[7:0], v[15:8]};
      2'd2:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
      default: return {24'h0, v[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input bit hit, input logic [31:0] m);
    if (!hit) return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return swap_out(sz, m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input string req, input bit wr, input logic [1:0] sz,
                      input logic [11:0] off, input logic [31:0] wd);
    bit hit;
    logic [31:0] mval;
    hit = exp_hit(sz, off);
    mval = hit ? smem[exp_reg(off)] : 32'h0;
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_size = sz; h_off = off; h_wdata = wd;
    #1;
    check({req, " strobe"}, {31'h0, t_stb}, {31'h0, hit});
    if (hit) begin
      check({req, " reg"}, {28'h0, t_reg}, {28'h0, exp_reg(off)});
      check({req, " size"}, {30'h0, t_size}, {30'h0, sz});
      if (wr) check({req, " wdata"}, t_wdata, swap_out(sz, wd));
    end
    @(posedge clk);
    #1;
    h_valid = 1'b0;
    if (wr && hit) smem[exp_reg(off)] = swap_out(sz, wd);
    @(negedge clk);
    check({req, " rvalid"}, {31'h0, h_rvalid}, {31'h0, !wr});
    if (!wr) check({req, " rdata"}, h_rdata, exp_rd(sz, hit, mval));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1DE0));
    for (int i = 0; i <= 8; i++) begin
      dmem[i] = 32'h1111_1111 * i + 32'hA0B0_C0D0;
      smem[i] = dmem[i];
    end
    h_valid = 1'b1; h_write = 1'b0; h_size = 2'd0; h_off = 12'h010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 ready in reset", {31'h0, h_ready}, 32'h0);
    check("R10 strobe in reset", {31'h0, t_stb}, 32'h0);
    check("R10 rvalid after reset", {31'h0, h_rvalid}, 32'h0);
    h_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R10 ready after reset", {31'h0, h_ready}, 32'h1);

    xfer("R2 write tf3", 1, 2'd0, 12'h030, 32'hDEAD_BE5A);
    xfer("R2 read tf3", 0, 2'd0, 12'h03C, 0);
    xfer("R2 read tf7", 0, 2'd0, 12'h070, 0);
    xfer("R3 write ctl slot8", 1, 2'd0, 12'h080, 32'h0000_0006);
    xfer("R3 read alt slot22", 0, 2'd0, 12'h160, 0);
    xfer("R3 write ctl slot22", 1, 2'd0, 12'h16F, 32'h0000_0002);
    xfer("R3 read alt slot8", 0, 2'd0, 12'h085, 0);
    xfer("R4 byte slot0 read", 0, 2'd0, 12'h000, 0);
    xfer("R4 byte slot9 write", 1, 2'd0, 12'h090, 32'h77);
    xfer("R4 byte slot255 read", 0, 2'd0, 12'hFF0, 0);
    xfer("R6 half write data", 1, 2'd1, 12'h000, 32'h0000_1234);
    xfer("R6 half read data", 0, 2'd1, 12'h004, 0);
    xfer("R7 word write data", 1, 2'd2, 12'h00C, 32'h0102_0304);
    xfer("R7 word read data", 0, 2'd2, 12'h000, 0);
    xfer("R5 half read slot1", 0, 2'd1, 12'h010, 0);
    xfer("R5 word read slot22", 0, 2'd2, 12'h160, 0);
    xfer("R5 word write slot3", 1, 2'd2, 12'h030, 32'hCAFE_F00D);
    xfer("R2 tf3 unchanged", 0, 2'd0, 12'h030, 0);
    xfer("R5 reserved size read", 0, 2'd3, 12'h000, 0);
    xfer("R8 byte read data path", 0, 2'd0, 12'h020, 0);
    xfer("R1 low bits ignored", 0, 2'd0, 12'h02F, 0);

    for (int n = 0; n < 400; n++) begin
      logic [11:0] off;
      logic [1:0]  sz;
      int pick = $urandom_range(0, 3);
      off = 12'($urandom);
      if (pick == 0) off[11:4] = 8'd0;
      else if (pick == 1) off[11:4] = 8'($urandom_range(1, 8));
      else if (pick == 2) off[11:4] = 8'd22;
      sz = 2'($urandom_range(0, 3));
      xfer("R9 random", 1'($urandom), sz, off, $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule